// File: doc/BRIEF.md
# SD Card Power-Cycle Sequencer

This block takes a memory card attached to an SD/MMC host through a safe power cycle. The host controller is put into reset and the card supply is switched off. While the supply is off, the clock, command and data pins are actively held low, so the card cannot draw power through its signal lines. The supply is then switched back on and allowed to ramp. Next the pins are driven high for a quiet interval. Finally the card clock is started, and the block reports that the first command may be issued.

All intervals come from one down-counter on the system clock. The millisecond length is derived from the system clock frequency parameter. The card clock is a divided copy of the system clock. Its rising edges are detected as a strobe in the system clock domain and counted before the ready flag is raised. The command and data engines, the regulator and clock-rate selection are outside the block. It only drives their reset and owns the pins while it runs.

Top module: `sd_pwr_cycle_seq`

## Requirements
- R1: When `rst_n` is low at a clock edge, the block returns to idle. In idle every output is 0, and it stays there until a start request is sampled.
- R2: A start sampled in idle raises `host_rst_o` and `busy_o` from the next clock. `host_rst_o` stays high for exactly RST_CYCLES clocks. `vcc_en_o` keeps its previous value while `host_rst_o` is high and falls on the clock where `host_rst_o` falls.
- R3: While `vcc_en_o` is 0 and `line_oe_o` is 1, `ck_o`, `cmd_o` and every bit of `dat_o` are 0.
- R4: The supply stays off with the pins driven low for exactly MS_CYCLES = SYS_CLK_HZ/1000 clocks, and then `vcc_en_o` rises.
- R5: After `vcc_en_o` rises, the pins stay driven low for RAMP_CYCLES clocks.
- R6: Next, `cmd_o` and `dat_o` are driven to all ones with `ck_o` low for MS_CYCLES clocks. The card clock is then enabled. It stays low for its first CK_HALF clocks and has a period of 2*CK_HALF clocks, so `ck_o` first rises MS_CYCLES+CK_HALF clocks after the high drive begins.
- R7: `ready_o` rises on the same clock as the INIT_CLKS-th (default 74) rising edge of `ck_o`, and `busy_o` falls on that clock. Afterwards `ready_o` stays high and `ck_o` keeps toggling.
- R8: A start request while `busy_o` is high is ignored. Every interval keeps its length and `host_rst_o` is not raised again.
- R9: A start sampled while `ready_o` is high begins a new sequence from the next clock: `ready_o`=0, `busy_o`=1, `host_rst_o`=1, `ck_o`=0, and `vcc_en_o` still 1.
- R10: While `host_rst_o` is high, `line_oe_o` is 0, so the pins are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a power cycle |
| host_rst_o | output | 1 | Reset to host command/data engines |
| vcc_en_o | output | 1 | Card supply enable |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | First command may be sent |
| line_oe_o | output | 1 | Output enable for clock, command and data pins |
| ck_o | output | 1 | Card clock pin level |
| cmd_o | output | 1 | Command pin level |
| dat_o | output | DAT_W | Data pin levels |

## Verification
The bench builds the block with SYS_CLK_HZ=8000, RAMP_CYCLES=5, RST_CYCLES=3 and CK_HALF=2. This shrinks the millisecond to 8 clocks and the card clock period to 4 clocks. With these values a whole sequence, including all 74 card-clock edges, lasts a few hundred clocks. Every interval can then be measured to the exact clock and compared against its expected length. It also leaves room to inject stray start requests inside each interval, to restart from the ready state, and to reset in mid-sequence.

// File: rtl/sdpc_pkg.sv
// Shared types for the card power-cycle sequencer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package sdpc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HRST,
        ST_CYCLE,
        ST_RAMP,
        ST_OFF,
        ST_ON,
        ST_READY
    } seq_state_e;

    typedef enum logic [1:0] {
        PAD_RELEASE,
        PAD_LOW,
        PAD_HIGH,
        PAD_CLOCKED
    } pad_mode_e;

endpackage

// File: rtl/sdpc_delay_timer.sv
// Interval down-counter. A load presets it to N-1, so the owning state
// lasts exactly N clocks. expired_o is high when the count is zero.
// Assumes every loaded value fits in W bits.
module sdpc_delay_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_q;

    // Preset on load, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/sdpc_card_clk.sv
// Card clock divider. While enabled it toggles every HALF system clocks,
// starting low. rise_o flags the system clock whose edge makes the card
// clock go high. Assumes HALF >= 1; the card clock is synchronous to clk.
module sdpc_card_clk #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic ck_o,
    output logic rise_o
);

    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] TERM = CW'(HALF - 1);

    logic [CW-1:0] div_q;
    logic          ck_q;

    // Divide down the system clock; hold low and cleared when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            div_q <= '0;
            ck_q  <= 1'b0;
        end else if (div_q == TERM) begin
            div_q <= '0;
            ck_q  <= ~ck_q;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign rise_o = en_i && (div_q == TERM) && !ck_q;
    assign ck_o   = ck_q && en_i;

endmodule

// File: rtl/sdpc_pad_mux.sv
// Maps the sequencer pad mode onto pin enable and levels.
// Assumes clock, command and data share one output enable.
module sdpc_pad_mux
    import sdpc_pkg::*;
#(
    parameter int DAT_W = 8
) (
    input  pad_mode_e        mode_i,
    input  logic             div_ck_i,
    output logic             oe_o,
    output logic             ck_o,
    output logic             cmd_o,
    output logic [DAT_W-1:0] dat_o
);

    // Select enable and level per mode.
    always_comb begin
        oe_o  = 1'b1;
        ck_o  = 1'b0;
        cmd_o = 1'b0;
        dat_o = '0;
        case (mode_i)
            PAD_RELEASE: oe_o = 1'b0;
            PAD_LOW:     ;
            PAD_HIGH: begin
                cmd_o = 1'b1;
                dat_o = '1;
            end
            PAD_CLOCKED: begin
                ck_o  = div_ck_i;
                cmd_o = 1'b1;
                dat_o = '1;
            end
            default: oe_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sd_pwr_cycle_seq.sv
// Card power-cycle sequencer: host reset, supply off with pins low,
// supply on and ramp, pins high, then card clock for INIT_CLKS edges.
// Assumes the supply regulator follows vcc_en_o and that the host
// engines honour host_rst_o within RST_CYCLES clocks.
module sd_pwr_cycle_seq
    import sdpc_pkg::*;
#(
    parameter int SYS_CLK_HZ  = 100_000_000,
    parameter int RAMP_CYCLES = 50_000,
    parameter int RST_CYCLES  = 16,
    parameter int CK_HALF     = 125,
    parameter int INIT_CLKS   = 74,
    parameter int DAT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             host_rst_o,
    output logic             vcc_en_o,
    output logic             busy_o,
    output logic             ready_o,
    output logic             line_oe_o,
    output logic             ck_o,
    output logic             cmd_o,
    output logic [DAT_W-1:0] dat_o
);

    localparam int MS_CYCLES = SYS_CLK_HZ / 1000;
    localparam int MAX_A     = (MS_CYCLES > RAMP_CYCLES) ? MS_CYCLES : RAMP_CYCLES;
    localparam int TMR_MAX   = (MAX_A > RST_CYCLES) ? MAX_A : RST_CYCLES;
    localparam int TW        = $clog2(TMR_MAX + 1);
    localparam int EW        = $clog2(INIT_CLKS + 1);
    localparam logic [EW-1:0] LAST_EDGE = EW'(INIT_CLKS - 1);

    seq_state_e    state_q, state_d;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;
    logic          vcc_q;
    logic [EW-1:0] edge_q;
    logic          clk_en;
    logic          div_ck;
    logic          div_rise;
    pad_mode_e     pad_mode;

    sdpc_delay_timer #(.W(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_done)
    );

    sdpc_card_clk #(.HALF(CK_HALF)) u_ckdiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (clk_en),
        .ck_o   (div_ck),
        .rise_o (div_rise)
    );

    sdpc_pad_mux #(.DAT_W(DAT_W)) u_pads (
        .mode_i   (pad_mode),
        .div_ck_i (div_ck),
        .oe_o     (line_oe_o),
        .ck_o     (ck_o),
        .cmd_o    (cmd_o),
        .dat_o    (dat_o)
    );

    // Next state and timer preset for the state being entered.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_IDLE, ST_READY: if (start_i) begin
                state_d  = ST_HRST;
                tmr_load = 1'b1;
                tmr_val  = TW'(RST_CYCLES - 1);
            end
            ST_HRST: if (tmr_done) begin
                state_d  = ST_CYCLE;
                tmr_load = 1'b1;
                tmr_val  = TW'(MS_CYCLES - 1);
            end
            ST_CYCLE: if (tmr_done) begin
                state_d  = ST_RAMP;
                tmr_load = 1'b1;
                tmr_val  = TW'(RAMP_CYCLES - 1);
            end
            ST_RAMP: if (tmr_done) begin
                state_d  = ST_OFF;
                tmr_load = 1'b1;
                tmr_val  = TW'(MS_CYCLES - 1);
            end
            ST_OFF: if (tmr_done) state_d = ST_ON;
            ST_ON: if (div_rise && edge_q == LAST_EDGE) state_d = ST_READY;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Supply enable: drop after host reset, restore after the low window.
    always_ff @(posedge clk) begin
        if (!rst_n)                               vcc_q <= 1'b0;
        else if (state_q == ST_HRST && tmr_done)  vcc_q <= 1'b0;
        else if (state_q == ST_CYCLE && tmr_done) vcc_q <= 1'b1;
    end

    // Count card clock rising edges while in power-on.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_ON) edge_q <= '0;
        else if (div_rise)              edge_q <= edge_q + 1'b1;
    end

    // Pad mode per state.
    always_comb begin
        case (state_q)
            ST_CYCLE, ST_RAMP: pad_mode = PAD_LOW;
            ST_OFF:            pad_mode = PAD_HIGH;
            ST_ON, ST_READY:   pad_mode = PAD_CLOCKED;
            default:           pad_mode = PAD_RELEASE;
        endcase
    end

    assign clk_en     = (state_q == ST_ON) || (state_q == ST_READY);
    assign host_rst_o = (state_q == ST_HRST);
    assign vcc_en_o   = vcc_q;
    assign busy_o     = (state_q != ST_IDLE) && (state_q != ST_READY);
    assign ready_o    = (state_q == ST_READY);

    // Checker: length of the current unpowered, driven-low run.
    localparam int LW = $clog2(MS_CYCLES + 2);
    localparam logic [LW-1:0] LSAT = '1;
    logic [LW-1:0] low_run_q;

    // Saturating run counter of supply-off cycles with the pins driven.
    always_ff @(posedge clk) begin
        if (!rst_n || vcc_en_o || !line_oe_o) low_run_q <= '0;
        else if (low_run_q != LSAT)           low_run_q <= low_run_q + 1'b1;
    end

    p_rst_precedes_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vcc_en_o) |-> $past(host_rst_o));

    p_lines_low_unpowered_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!vcc_en_o && line_oe_o) |-> (!ck_o && !cmd_o && dat_o == '0));

    p_min_low_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vcc_en_o) |-> (int'(low_run_q) >= MS_CYCLES));

    p_ready_powered_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (vcc_en_o && line_oe_o && cmd_o && (&dat_o)));

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_rst_o) |-> $past(!busy_o));

    p_release_in_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_rst_o |-> !line_oe_o);

endmodule

// File: tb/sd_pwr_cycle_seq_tb_top.sv
module sd_pwr_cycle_seq_tb_top;

    localparam int SYS_HZ = 8000;
    localparam int MS     = SYS_HZ / 1000;
    localparam int RAMP   = 5;
    localparam int RSTC   = 3;
    localparam int HALF   = 2;
    localparam int NINIT  = 74;

    // Phase codes seen at the ports: 1 host reset, 2 unpowered low,
    // 3 ramp low, 4 driven high with clock not yet started.
    localparam int NPH = 4;
    localparam int PH_ID  [NPH] = '{1, 2, 3, 4};
    localparam int PH_LEN [NPH] = '{RSTC, MS, RAMP, MS + HALF};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       host_rst_o, vcc_en_o, busy_o, ready_o, line_oe_o, ck_o, cmd_o;
    logic [7:0] dat_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sd_pwr_cycle_seq #(
        .SYS_CLK_HZ (SYS_HZ),
        .RAMP_CYCLES(RAMP),
        .RST_CYCLES (RSTC),
        .CK_HALF    (HALF),
        .INIT_CLKS  (NINIT),
        .DAT_W      (8)
    ) dut_i (
        .clk, .rst_n, .start_i, .host_rst_o, .vcc_en_o, .busy_o,
        .ready_o, .line_oe_o, .ck_o, .cmd_o, .dat_o
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int phase_of();
        if (host_rst_o && !line_oe_o) return 1;
        if (line_oe_o && !vcc_en_o && !ck_o && !cmd_o && dat_o == 8'h00) return 2;
        if (line_oe_o && vcc_en_o && !ck_o && !cmd_o && dat_o == 8'h00) return 3;
        if (line_oe_o && vcc_en_o && !ck_o && cmd_o && dat_o == 8'hFF && !ready_o) return 4;
        return 0;
    endfunction

    task automatic all_zero(input string req);
        chk({host_rst_o, vcc_en_o, busy_o, ready_o, line_oe_o, ck_o, cmd_o} == 7'b0,
            req, {host_rst_o, vcc_en_o, busy_o, ready_o, line_oe_o, ck_o, cmd_o}, 0);
        chk(dat_o == 8'h00, req, dat_o, 0);
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Measure each phase length; optionally inject stray starts (R8).
    task automatic run_phases(input bit inject);
        bit busy_drop = 1'b0;
        int rises;
        bit prev;
        for (int i = 0; i < NPH; i++) begin
            int n = 0;
            while (phase_of() == PH_ID[i] && n < 5000) begin
                n++;
                if (!busy_o) busy_drop = 1'b1;
                start_i = inject && (i != 2) && (n == 2);
                @(negedge clk);
            end
            start_i = 1'b0;
            case (i)
                0: chk(n == PH_LEN[i], inject ? "R8 host reset length" : "R2 host reset length", n, PH_LEN[i]);
                1: chk(n == PH_LEN[i], "R4 unpowered low window", n, PH_LEN[i]);
                2: chk(n == PH_LEN[i], "R5 ramp low window", n, PH_LEN[i]);
                default: chk(n == PH_LEN[i], "R6 high drive before clock", n, PH_LEN[i]);
            endcase
        end
        rises = ck_o ? 1 : 0;
        prev = ck_o;
        for (int g = 0; g < 5000 && !ready_o; g++) begin
            if (!busy_o) busy_drop = 1'b1;
            start_i = inject && (g == 20);
            @(negedge clk);
            start_i = 1'b0;
            if (ck_o && !prev) rises++;
            prev = ck_o;
        end
        chk(rises == NINIT, inject ? "R8 edge count with stray start" : "R7 edges before ready", rises, NINIT);
        chk(ready_o && !busy_o, "R7 ready up busy down", {ready_o, busy_o}, 2);
        chk(!busy_drop, "R2 busy held through sequence", busy_drop, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int r;
        bit p;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        all_zero("R1 reset state");
        repeat (5) @(negedge clk);
        all_zero("R1 idle without start");

        // First sequence from idle.
        pulse_start();
        chk(host_rst_o && busy_o, "R2 reset and busy raised", {host_rst_o, busy_o}, 3);
        chk(!vcc_en_o, "R2 supply keeps prior value", vcc_en_o, 0);
        chk(!line_oe_o, "R10 pins released in host reset", line_oe_o, 0);
        run_phases(1'b0);

        // Clock keeps running after ready.
        r = 0;
        p = ck_o;
        for (int k = 0; k < 4 * HALF; k++) begin
            @(negedge clk);
            if (ck_o && !p) r++;
            p = ck_o;
        end
        chk(r == 2, "R7 clock runs after ready", r, 2);
        chk(ready_o, "R7 ready held", ready_o, 1);

        // Restart from ready, with stray starts while busy.
        pulse_start();
        chk(!ready_o && busy_o, "R9 ready drops busy rises", {ready_o, busy_o}, 1);
        chk(host_rst_o, "R9 host reset on restart", host_rst_o, 1);
        chk(vcc_en_o, "R9 supply held during host reset", vcc_en_o, 1);
        chk(!ck_o && !line_oe_o, "R9 clock stopped pins released", {ck_o, line_oe_o}, 0);
        run_phases(1'b1);

        // Reset in mid-sequence.
        pulse_start();
        repeat (10) @(negedge clk);
        chk(busy_o, "R1 busy before mid reset", busy_o, 1);
        rst_n = 1'b0;
        @(negedge clk);
        all_zero("R1 mid-sequence reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        all_zero("R1 idle after mid reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule